// File: doc/BRIEF.md
# Receive Byte Buffer with Watermark Flow Control

This block holds bytes arriving from a serial receiver until a host reader takes them. Bytes go in at the write side one per clock when `wr_en` is high. They come out in arrival order at the read side. The oldest byte is always visible on `rd_data`, and `rd_en` removes it. The buffer reports how many bytes it holds, and whether it is full or empty.

The block drives an active-low ready-to-send line for the remote transmitter. When hardware flow control is enabled and occupancy reaches a watermark, the line goes high and the sender is told to pause. The watermark sits well below the full depth, so bytes already on the wire still have room. A sticky flag records any byte that arrived while the buffer was full. A flush input empties the buffer in one clock, for example when the port is opened.

Top module: `rxbuf_rts`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, `overrun` is 0 and `rts_n` is 0.
- R2: Bytes leave in the order they were written, and `rd_data` shows the oldest stored byte whenever `empty` is 0.
- R3: On a clock edge, an accepted write adds one to `level` and an accepted read subtracts one. When a write and a read are both accepted, `level` is unchanged.
- R4: `full` is 1 exactly when `level` equals DEPTH (default 576). `empty` is 1 exactly when `level` is 0.
- R5: A write while `full` is 1 is dropped, and the stored contents are unchanged. It sets `overrun`, which stays 1 until a flush. A read in the same cycle still removes a byte.
- R6: A read while `empty` is 1 has no effect, and `level` stays 0.
- R7: With `hw_fc_en` = 1, `rts_n` is 1 when `level` is at least WATERMARK (default 383). It is 0 as soon as `level` falls below WATERMARK, with no hysteresis.
- R8: With `hw_fc_en` = 0, `rts_n` is 0 whatever the occupancy.
- R9: A flush empties the buffer and clears `overrun` on the next edge. It takes priority over any read or write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request from the receiver |
| wr_data | input | WIDTH | Byte to store |
| rd_en | input | 1 | Read request; removes the oldest byte |
| rd_data | output | WIDTH | Oldest stored byte (first-word fall-through) |
| flush | input | 1 | Empty the buffer and clear the overrun flag |
| hw_fc_en | input | 1 | Enable hardware flow control on `rts_n` |
| level | output | $clog2(DEPTH+1) | Current occupancy |
| full | output | 1 | Buffer holds DEPTH bytes |
| empty | output | 1 | Buffer holds no bytes |
| overrun | output | 1 | Sticky flag: a write arrived while full |
| rts_n | output | 1 | Active-low ready to send |

## Verification
Each read pointer or count error appears on a port one clock after the edge that caused it.
- A wrong read pointer shows a mismatched `rd_data` on the next cycle.
- A count that drifts from the pointers makes `level` differ from the reference queue size immediately.
- The same drift then moves `full`, `empty` and `rts_n` at the wrong occupancy.

Drops at full can only be told apart from accepted writes by the order of bytes read out afterwards. For that reason the bench drains a full buffer completely and compares every byte.

// File: rtl/rxbuf_rts.sv
module rxbuf_rts #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 576,
  parameter int WATERMARK = 383
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  input  logic                       flush,
  input  logic                       hw_fc_en,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       overrun,
  output logic                       rts_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             ovr;

  wire do_wr = wr_en && !full && !flush;
  wire do_rd = rd_en && !empty && !flush;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign level   = count;
  assign overrun = ovr;
  assign rd_data = mem[rptr];
  assign rts_n   = hw_fc_en && (count >= CW'(WATERMARK));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) ovr <= 1'b1;
    end
  end

  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  a_r3_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !full && !empty && !flush) |=> $stable(level));
  a_r5_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> overrun);
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en && !flush) |=> empty);
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !overrun && !rts_n));
endmodule

// File: tb/rxbuf_rts_tb.sv
module rxbuf_rts_tb;
  localparam int WIDTH = 8;
  localparam int DEPTH = 576;
  localparam int WM    = 383;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, rd_en = 0, flush = 0, hw_fc_en = 1;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic [CW-1:0] level;
  logic full, empty, overrun, rts_n;

  int checks = 0, fails = 0;
  bit done = 0;
  byte unsigned q[$];
  bit m_ovr = 0;

  always #10 clk = ~clk;

  rxbuf_rts #(.WIDTH(WIDTH), .DEPTH(DEPTH), .WATERMARK(WM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .flush(flush), .hw_fc_en(hw_fc_en),
    .level(level), .full(full), .empty(empty), .overrun(overrun), .rts_n(rts_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n = q.size();
    chk("R3 level", int'(level), n);
    chk("R4 full", int'(full), int'(n == DEPTH));
    chk("R4 empty", int'(empty), int'(n == 0));
    chk("R5 overrun", int'(overrun), int'(m_ovr));
    if (n != 0) chk("R2 rd_data", int'(rd_data), int'(q[0]));
    if (hw_fc_en) chk("R7 rts_n", int'(rts_n), int'(n >= WM));
    else          chk("R8 rts_n", int'(rts_n), 0);
  endtask

  // Compare at the falling edge, then drive the next cycle and advance the model.
  task automatic step(input bit w, input bit r, input bit f, input byte unsigned d, input bit fc);
    bit fm, em;
    @(negedge clk);
    compare_all();
    wr_en = w; rd_en = r; flush = f; wr_data = d; hw_fc_en = fc;
    if (f) begin
      q.delete(); m_ovr = 0;
    end else begin
      fm = (q.size() == DEPTH);
      em = (q.size() == 0);
      if (w && fm) m_ovr = 1;
      if (r && !em) void'(q.pop_front());
      if (w && !fm) q.push_back(d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    byte unsigned cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    rst_n = 1;

    // R6: read on empty does nothing
    step(0, 1, 0, 8'h00, 1);
    step(0, 1, 0, 8'h00, 1);
    @(negedge clk); chk("R6 level after empty read", int'(level), 0);

    // Mixed random traffic at low occupancy
    for (int i = 0; i < 400; i++) step($urandom_range(0, 1), $urandom_range(0, 1), 0, 8'($urandom), 1);

    // Fill to full, crossing the watermark (R7), then overflow (R5)
    for (int i = 0; i < DEPTH + 10; i++) begin
      step(1, 0, 0, cnt, 1); cnt++;
    end
    // Read and write together while full: read pops, write dropped
    step(1, 1, 0, 8'hEE, 1);
    step(0, 0, 0, 8'h00, 1);
    // Simultaneous read/write in the middle-high region keeps level (R3)
    for (int i = 0; i < 20; i++) step(1, 1, 0, 8'($urandom), 1);
    // Drain around the watermark to see rts_n drop without hysteresis
    for (int i = 0; i < 250; i++) step(0, 1, 0, 8'h00, 1);
    for (int i = 0; i < 10; i++) step(1, 0, 0, 8'($urandom), 1);
    for (int i = 0; i < 10; i++) step(0, 1, 0, 8'h00, 1);
    // Flow control disabled above the watermark (R8)
    for (int i = 0; i < 100; i++) step(1, 0, 0, 8'($urandom), 0);
    for (int i = 0; i < 40; i++) step($urandom_range(0, 1), $urandom_range(0, 1), 0, 8'($urandom), 0);
    // Flush with simultaneous write and read (R9)
    step(1, 1, 1, 8'h55, 1);
    step(0, 0, 0, 8'h00, 1);
    @(negedge clk);
    chk("R9 level after flush", int'(level), 0);
    chk("R9 overrun after flush", int'(overrun), 0);
    // Full drain check of order after refilling and overflowing
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 8'($urandom), 1);
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1, 0, 8'h00, 1);
    step(1, 0, 1, 8'h11, 1);
    for (int i = 0; i < 2000; i++) step($urandom_range(0, 3) != 0, $urandom_range(0, 1), ($urandom_range(0, 499) == 0), 8'($urandom), $urandom_range(0, 7) != 0);
    step(0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 8'h00, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule